// File: doc/BRIEF.md
# Shader Flow Control Sequencer

This block holds the program counter of a small data-parallel processor and decides which instruction runs next. A pulse on `start` resets the counter to instruction zero. Each cycle the sequencer addresses an instruction memory and reads a six-word instruction from it. It then sorts the instruction into one of three kinds: arithmetic, input-read or flow control. Arithmetic and input-read instructions are issued to their units. Flow-control instructions are handled inside the block.

Flow control covers unconditional jumps and jumps on the ALU result flag or on a constant boolean flag. It also covers counted loops and subroutine call and return. Loops and calls share one return stack that nests at most four levels. Loop trip counts come from a bank of limit registers that only the host port writes. A program ends with a one-cycle `done` pulse. Stack misuse raises a sticky `fault` and stops the program.

Top module: `shader_flow_seq`

## Requirements
- R1: A `start` pulse sets the program counter to 0 and begins execution; without flow control, the counter steps by one instruction each cycle, and `issue_pc` and `imem_addr` show it.
- R2: The kind field is bits [31:30] of word 0. Value 00 raises `issue_alu` and value 01 raises `issue_inp` in the cycle the instruction is addressed. Values 1x are flow control and raise neither output.
- R3: The flow opcode is bits [27:24] of word 0 and the target index is bits [8:0]. Opcode 0 always jumps to the target.
- R4: Opcode 1 jumps only when `alu_cond` is high. Opcode 2 jumps only when `const_flags[s]` is high, where s is bits [19:16]. Otherwise both fall through to the next instruction.
- R5: Opcode 3 opens a loop whose limit comes from host register s (bits [19:16]), written through `host_we`/`host_idx`/`host_limit`. Opcode 4 closes the innermost loop. The loop body runs exactly limit times, and loops nest.
- R6: When the selected limit is zero, opcode 3 jumps straight to its target, which is the instruction after the matching loop end.
- R7: Opcode 5 pushes the next index and jumps to the target. Opcode 6 pops and returns there. Calls and loops together nest up to four levels without error.
- R8: A push at depth four, or a pop (opcode 4 or 6) at depth zero, sets `fault`. It also stops issue and gives no `done`. `fault` stays set until reset or the next `start`.
- R9: Opcode 7 ends the program. `done` pulses high for one cycle, one cycle after the end instruction is addressed, and issue then stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin program at index 0 |
| imem_addr | output | IW | Instruction index being fetched |
| imem_data | input | 32*WORDS | Instruction read back (combinational memory) |
| alu_cond | input | 1 | ALU result flag for conditional jumps |
| const_flags | input | NFLAG | Constant boolean flags |
| host_we | input | 1 | Host write strobe for loop limits |
| host_idx | input | log2(NLOOP) | Loop-limit register selected by host |
| host_limit | input | CNT_W | Loop-limit value written by host |
| issue_alu | output | 1 | Arithmetic instruction issued |
| issue_inp | output | 1 | Input-read instruction issued |
| issue_pc | output | IW | Index of the issued instruction |
| issue_word | output | 32*WORDS | Instruction words passed to the units |
| done | output | 1 | One-cycle end-of-program pulse |
| fault | output | 1 | Sticky nesting fault |

## Verification
Straight-line code with mixed kinds exposes classification and sequential stepping. One jump program runs under each value of the ALU flag and under different constant-flag patterns. The three runs take visibly different paths, so the tests can tell which condition source each opcode reads. Loop limits of zero, one and three, plus a nested pair, separate skip, single pass and repeat, and check that inner and outer counts stay apart. A call chain four deep is compared with one five deep, and bare returns or loop ends are run at depth zero, to mark exactly where the fault boundary lies.

// File: rtl/shader_flow_seq.sv
module shader_flow_seq #(
  parameter int IW    = 9,
  parameter int WORDS = 6,
  parameter int CNT_W = 8,
  parameter int NLOOP = 4,
  parameter int NFLAG = 16,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic [IW-1:0]          imem_addr,
  input  logic [32*WORDS-1:0]    imem_data,
  input  logic                   alu_cond,
  input  logic [NFLAG-1:0]       const_flags,
  input  logic                   host_we,
  input  logic [$clog2(NLOOP)-1:0] host_idx,
  input  logic [CNT_W-1:0]       host_limit,
  output logic                   issue_alu,
  output logic                   issue_inp,
  output logic [IW-1:0]          issue_pc,
  output logic [32*WORDS-1:0]    issue_word,
  output logic                   done,
  output logic                   fault
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int DIW = $clog2(DEPTH);
  localparam int LSW = $clog2(NLOOP);
  localparam int FSW = $clog2(NFLAG);

  logic              running;
  logic [IW-1:0]     pc, pc_n, ret_addr;
  logic [SPW-1:0]    sp;
  logic [DIW-1:0]    top;
  logic [IW-1:0]     st_addr [DEPTH];
  logic [CNT_W-1:0]  st_cnt  [DEPTH];
  logic [CNT_W-1:0]  lim     [NLOOP];
  logic [CNT_W-1:0]  sel_lim, push_cnt;
  logic              push, pop, dec, bad, fin;

  wire [1:0]    kind = imem_data[31:30];
  wire [3:0]    op   = imem_data[27:24];
  wire [IW-1:0] tgt  = imem_data[IW-1:0];
  wire          flow = running && kind[1];

  assign imem_addr  = pc;
  assign issue_pc   = pc;
  assign issue_word = imem_data;
  assign issue_alu  = running && kind == 2'b00;
  assign issue_inp  = running && kind == 2'b01;
  assign top        = DIW'(sp - SPW'(1));
  assign ret_addr   = pc + IW'(1);
  assign sel_lim    = lim[imem_data[16 +: LSW]];

  always_comb begin
    pc_n = ret_addr;
    push = 1'b0;
    pop  = 1'b0;
    dec  = 1'b0;
    fin  = 1'b0;
    push_cnt = sel_lim;
    if (flow) begin
      case (op)
        4'd0: pc_n = tgt;
        4'd1: if (alu_cond) pc_n = tgt;
        4'd2: if (const_flags[imem_data[16 +: FSW]]) pc_n = tgt;
        4'd3: if (sel_lim == '0) pc_n = tgt; else push = 1'b1;
        4'd4: if (st_cnt[top] > CNT_W'(1)) begin
                dec  = 1'b1;
                pc_n = st_addr[top];
              end else pop = 1'b1;
        4'd5: begin push = 1'b1; push_cnt = '0; pc_n = tgt; end
        4'd6: begin pop = 1'b1; pc_n = st_addr[top]; end
        4'd7: fin = 1'b1;
        default: ;
      endcase
    end
    bad = (push && sp == SPW'(DEPTH)) || ((pop || op == 4'd4) && flow && sp == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
      sp      <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        pc      <= '0;
        sp      <= '0;
        fault   <= 1'b0;
      end else if (running) begin
        if (bad) begin
          fault   <= 1'b1;
          running <= 1'b0;
        end else if (fin) begin
          done    <= 1'b1;
          running <= 1'b0;
        end else begin
          pc <= pc_n;
          if (push) sp <= sp + SPW'(1);
          else if (pop) sp <= sp - SPW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (running && !start && !bad) begin
      if (push) begin
        st_addr[sp[DIW-1:0]] <= ret_addr;
        st_cnt[sp[DIW-1:0]]  <= push_cnt;
      end else if (dec) begin
        st_cnt[top] <= st_cnt[top] - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOOP; i++) lim[i] <= '0;
    end else if (host_we) begin
      lim[host_idx] <= host_limit;
    end
  end
endmodule

// File: rtl/shader_flow_seq_chk.sv
module shader_flow_seq_chk #(
  parameter int IW    = 9,
  parameter int SPW   = 3,
  parameter int DEPTH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           issue_alu,
  input logic           issue_inp,
  input logic [IW-1:0]  issue_pc,
  input logic           done,
  input logic           fault,
  input logic [SPW-1:0] sp
);
  p_start_pc0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> issue_pc == '0);

  p_one_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_alu && issue_inp));

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));

  p_fault_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !start |=> fault && !issue_alu && !issue_inp && !done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !issue_alu && !issue_inp);
endmodule

bind shader_flow_seq shader_flow_seq_chk #(.IW(IW), .SPW(SPW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .issue_alu(issue_alu),
  .issue_inp(issue_inp), .issue_pc(issue_pc), .done(done), .fault(fault), .sp(sp)
);

// File: tb/shader_flow_seq_tb_top.sv
module shader_flow_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic alu_cond = 1'b0, host_we = 1'b0;
  logic [15:0] const_flags = '0;
  logic [1:0] host_idx = '0;
  logic [7:0] host_limit = '0;
  logic [8:0] imem_addr, issue_pc;
  logic [191:0] imem_data, issue_word;
  logic issue_alu, issue_inp, done, fault;
  logic [31:0] mem [512];
  logic [9:0] expq [$];
  int checks = 0, errors = 0, done_cnt = 0;

  always #10 clk = ~clk;
  assign imem_data = {160'b0, mem[imem_addr]};

  shader_flow_seq dut_i (.*);

  function automatic logic [31:0] fc(int op, int sel, int tgt);
    return {2'b10, 2'b00, 4'(op), 4'b0, 4'(sel), 7'b0, 9'(tgt)};
  endfunction
  localparam logic [31:0] ALU = 32'h0000_0000;
  localparam logic [31:0] INP = 32'h4000_0000;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = fc(7, 0, 0);
  endtask

  task automatic expect_issue(bit is_inp, int pc);
    expq.push_back({is_inp, 9'(pc)});
  endtask

  task automatic set_limit(int idx, int val);
    @(negedge clk);
    host_we = 1'b1; host_idx = 2'(idx); host_limit = 8'(val);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) done_cnt++;
        if (issue_alu || issue_inp) begin
          if (expq.size() == 0) begin
            chk("R2 unexpected issue pc", int'(issue_pc), -1);
          end else begin
            logic [9:0] e;
            e = expq.pop_front();
            chk("R2 issued kind", int'(issue_inp), int'(e[9]));
            chk("R1 issued pc", int'(issue_pc), int'(e[8:0]));
          end
        end
      end
    end
  end

  task automatic run(string tag, int exp_done, int exp_fault);
    done_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk({tag, " leftover expected issues"}, expq.size(), 0);
    chk({tag, " done pulses"}, done_cnt, exp_done);
    chk({tag, " fault"}, int'(fault), exp_fault);
    expq.delete();
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic load_jumps();
    clear_mem();
    mem[0] = fc(0, 0, 5);  mem[5] = ALU;  mem[6] = fc(1, 0, 10);
    mem[7] = ALU;          mem[8] = fc(0, 0, 10);
    mem[10] = ALU;         mem[11] = fc(2, 3, 20);
    mem[12] = INP;         mem[20] = ALU;
  endtask

  initial begin : driver
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R9 reset done", int'(done), 0);
    chk("R8 reset fault", int'(fault), 0);
    chk("R2 reset issue", int'(issue_alu | issue_inp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle after reset", int'(issue_alu | issue_inp), 0);

    // R1 R2 R9: straight-line code
    clear_mem();
    mem[0] = ALU; mem[1] = INP; mem[2] = ALU; mem[3] = INP;
    expect_issue(0, 0); expect_issue(1, 1); expect_issue(0, 2); expect_issue(1, 3);
    run("R1 R9 straight", 1, 0);

    // R3 R4: jumps, ALU flag high
    load_jumps(); alu_cond = 1'b1; const_flags = 16'h0004;
    expect_issue(0, 5); expect_issue(0, 10); expect_issue(1, 12);
    run("R4 alu taken", 1, 0);
    // R4: ALU flag low
    alu_cond = 1'b0;
    expect_issue(0, 5); expect_issue(0, 7); expect_issue(0, 10); expect_issue(1, 12);
    run("R4 alu not taken", 1, 0);
    // R4: constant flag 3 set
    alu_cond = 1'b1; const_flags = 16'h0008;
    expect_issue(0, 5); expect_issue(0, 10); expect_issue(0, 20);
    run("R4 const taken", 1, 0);
    const_flags = '0;

    // R5: loop limit 3
    clear_mem();
    mem[0] = fc(3, 1, 3); mem[1] = ALU; mem[2] = fc(4, 0, 0); mem[3] = INP;
    set_limit(1, 3);
    for (int k = 0; k < 3; k++) expect_issue(0, 1);
    expect_issue(1, 3);
    run("R5 loop x3", 1, 0);
    set_limit(1, 1);
    expect_issue(0, 1); expect_issue(1, 3);
    run("R5 loop x1", 1, 0);
    // R6: zero limit skips
    set_limit(1, 0);
    expect_issue(1, 3);
    run("R6 loop zero", 1, 0);

    // R5: nested loops 2 x 2
    clear_mem();
    mem[0] = fc(3, 1, 6); mem[1] = fc(3, 2, 4); mem[2] = ALU; mem[3] = fc(4, 0, 0);
    mem[4] = INP; mem[5] = fc(4, 0, 0);
    set_limit(1, 2); set_limit(2, 2);
    for (int k = 0; k < 2; k++) begin
      expect_issue(0, 2); expect_issue(0, 2); expect_issue(1, 4);
    end
    run("R5 nested", 1, 0);

    // R7: call chain four deep
    clear_mem();
    mem[0] = fc(5, 0, 10); mem[10] = fc(5, 0, 20); mem[11] = INP; mem[12] = fc(6, 0, 0);
    mem[20] = fc(5, 0, 30); mem[21] = fc(6, 0, 0);
    mem[30] = fc(5, 0, 40); mem[31] = fc(6, 0, 0);
    mem[40] = ALU; mem[41] = fc(6, 0, 0); mem[1] = ALU;
    expect_issue(0, 40); expect_issue(1, 11); expect_issue(0, 1);
    run("R7 depth four", 1, 0);

    // R8: fifth level overflows
    mem[41] = fc(5, 0, 50); mem[50] = ALU;
    expect_issue(0, 40);
    run("R8 overflow", 0, 1);

    // R8: fault clears on start
    clear_mem(); mem[0] = INP;
    expect_issue(1, 0);
    run("R8 cleared by start", 1, 0);

    // R8: return at depth zero
    clear_mem(); mem[0] = ALU; mem[1] = fc(6, 0, 0); mem[2] = INP;
    expect_issue(0, 0);
    run("R8 return underflow", 0, 1);

    // R8: loop end at depth zero
    clear_mem(); mem[0] = fc(4, 0, 0); mem[1] = ALU;
    run("R8 loop end underflow", 0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule